// File: doc/BRIEF.md
# Buffered Up-Counting Timer Base

This block is the time base of a general-purpose timer. A clock prescaler divides the timer clock into count ticks. On each tick a 16-bit counter steps upward from zero. When it reaches the active period it returns to zero, emits a one-cycle overflow pulse and sets a sticky overflow flag. Software programs the block through a simple write port. The port carries a control word, a period value, a divide value, and a command that clears the flag.

The period and the divide value that the counter uses come from shadow copies, and these copies are refreshed only at an overflow. The period buffer can be switched off, so that a newly written period acts at once. An event-disable control suppresses the overflow pulse, the flag and the shadow refresh, while the counter still wraps. Counting starts one clock after the enable bit is written, because the enable passes through a synchronizing stage.

Top module: `utb_timebase`

## Requirements
- R1: After synchronous reset, count, period_active, divide_active, ovf_evt, ovf_flag and run are all zero.
- R2: A write is taken on the rising clock when wr_en is 1. Address 0 is control: bit0 enable, bit1 period buffering, bit2 event disable, bits[4:3] mode, bit5 direction. Address 1 is the period preload. Address 2 is the divide preload. Address 3 with data bit0 = 1 clears the flag.
- R3: run goes high one clock after the enable bit is written as 1. The first counter step happens on the clock after that.
- R4: The prescaler produces one count tick every divide_active + 1 clocks. A divide value of 0 ticks on every clock.
- R5: On each tick the count rises by one. A tick that finds the count at or above the effective period sets the count to 0 instead. That wrap raises ovf_evt for exactly the cycle in which the count shows 0.
- R6: ovf_flag is set by every overflow pulse and stays set until a clear command. If a clear and an overflow fall on the same clock, the flag stays set.
- R7: With period buffering on, a written period goes only to the preload. period_active, which is the period the counter uses, takes the preload value at an overflow.
- R8: With period buffering off, the counter compares against the period preload directly. A written period smaller than the current count ends the cycle on the next tick.
- R9: divide_active takes the divide preload only at an overflow. A written divide value changes nothing before then.
- R10: With event disable set, the counter still wraps, but there is no ovf_evt, the flag is not set, and neither shadow changes.
- R11: With enable cleared, the counter and the prescaler hold their values.
- R12: The counter advances only when mode is 00 and direction is 0. Any other combination holds the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| count | output | 16 | Counter value |
| ovf_evt | output | 1 | One-cycle overflow pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| run | output | 1 | Synchronized enable |
| period_active | output | 16 | Period shadow |
| divide_active | output | 16 | Divide shadow |

## Verification
Two things can land on the same clock edge. The first pair is a clear command for the flag and an overflow that sets it. The second pair is a register write and the shadow refresh that samples the preload. The bench predicts, from its own model state, the edge on which the next overflow will occur, and issues the flag clear for exactly that edge. It then expects the flag to read 1. A later clear on a quiet edge must read 0. Period and divide writes made while the counter runs meet overflow edges at arbitrary phases. The shadow values are compared every cycle against the model, which refreshes the shadows from the preload value held before the edge.

// File: rtl/utb_pkg.sv
package utb_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;

    // Control word, LSB first: en, buf_en, evt_dis, mode[1:0], dir
    typedef struct packed {
        logic       dir;
        logic [1:0] mode;
        logic       evt_dis;
        logic       buf_en;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic up_mode(ctrl_t c);
        return (c.mode == 2'b00) && !c.dir;
    endfunction

endpackage

// File: rtl/utb_regs.sv
module utb_regs
    import utb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  per_pre,
    output logic [PSC_W-1:0]  div_pre,
    output logic              run,
    output logic              ovf_flag
);

    logic clr_req;
    assign clr_req = wr_en && (wr_addr == A_CLR) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            per_pre <= '0;
            div_pre <= '0;
            run     <= 1'b0;
        end else begin
            run <= ctrl.en;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:  ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    A_PER:   per_pre <= wr_data[CNT_W-1:0];
                    A_DIV:   div_pre <= wr_data[PSC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Set has priority over clear
    always_ff @(posedge clk) begin
        if (rst)
            ovf_flag <= 1'b0;
        else if (set_flag)
            ovf_flag <= 1'b1;
        else if (clr_req)
            ovf_flag <= 1'b0;
    end

    assert_flag_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(clr_req));

    assert_run_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(ctrl.en));

endmodule

// File: rtl/utb_prescaler.sv
module utb_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             reload,
    input  logic [PSC_W-1:0] div_pre,
    output logic             tick,
    output logic [PSC_W-1:0] div_sh
);

    logic [PSC_W-1:0] psc_q;

    assign tick = active && (psc_q == div_sh);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q  <= '0;
            div_sh <= '0;
        end else begin
            if (active)
                psc_q <= tick ? '0 : psc_q + 1'b1;
            if (reload)
                div_sh <= div_pre;
        end
    end

    assert_psc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        psc_q <= div_sh);

    assert_psc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> $stable(psc_q));

endmodule

// File: rtl/utb_counter.sv
module utb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             buf_en,
    input  logic             evt_dis,
    input  logic [CNT_W-1:0] per_pre,
    output logic             reload,
    output logic             ovf_evt,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] per_sh
);

    logic [CNT_W-1:0] per_eff;
    logic             wrap;

    assign per_eff = buf_en ? per_sh : per_pre;
    assign wrap    = tick && (count >= per_eff);
    assign reload  = wrap && !evt_dis;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            per_sh  <= '0;
            ovf_evt <= 1'b0;
        end else begin
            if (tick)
                count <= wrap ? '0 : count + 1'b1;
            ovf_evt <= reload;
            if (reload)
                per_sh <= per_pre;
        end
    end

    assert_evt_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> (count == '0));

    assert_per_refresh_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(per_sh) |-> ovf_evt);

    assert_no_refresh_R10: assert property (@(posedge clk) disable iff (rst)
        $past(evt_dis) |-> !ovf_evt);

endmodule

// File: rtl/utb_timebase.sv
module utb_timebase
    import utb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_evt,
    output logic              ovf_flag,
    output logic              run,
    output logic [CNT_W-1:0]  period_active,
    output logic [PSC_W-1:0]  divide_active
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_pre;
    logic [PSC_W-1:0] div_pre;
    logic             reload;
    logic             tick;
    logic             active;

    assign active = run && up_mode(ctrl);

    utb_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_flag (reload),
        .ctrl     (ctrl),
        .per_pre  (per_pre),
        .div_pre  (div_pre),
        .run      (run),
        .ovf_flag (ovf_flag)
    );

    utb_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .reload  (reload),
        .div_pre (div_pre),
        .tick    (tick),
        .div_sh  (divide_active)
    );

    utb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .buf_en  (ctrl.buf_en),
        .evt_dis (ctrl.evt_dis),
        .per_pre (per_pre),
        .reload  (reload),
        .ovf_evt (ovf_evt),
        .count   (count),
        .per_sh  (period_active)
    );

    assert_cnt_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> $stable(count));

    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(up_mode(ctrl)) |-> $stable(count));

    assert_div_refresh_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(divide_active) |-> ovf_evt);

    assert_flag_on_evt_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> ovf_flag);

endmodule

// File: tb/sim_utb_timebase.sv
`timescale 1ns/1ps
module sim_utb_timebase;

    localparam int CW = 16;
    localparam realtime TCK = 8.0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [CW-1:0] count;
    logic          ovf_evt, ovf_flag, run;
    logic [CW-1:0] period_active;
    logic [15:0]   divide_active;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 0;
    string phase = "R1";

    always #(TCK/2) clk = ~clk;

    utb_timebase u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .ovf_evt(ovf_evt), .ovf_flag(ovf_flag), .run(run),
        .period_active(period_active), .divide_active(divide_active)
    );

    // Behavioural reference model
    bit m_en, m_buf, m_dis, m_dir, m_run, m_flag, m_evt;
    int m_mode, m_per_pre, m_div_pre, m_per_sh, m_div_sh, m_psc, m_cnt;

    function automatic bit m_tick();
        return m_run && m_mode == 0 && !m_dir && m_psc == m_div_sh;
    endfunction

    function automatic bit m_evt_next();
        int eff = m_buf ? m_per_sh : m_per_pre;
        return m_tick() && m_cnt >= eff && !m_dis;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_buf = 0; m_dis = 0; m_dir = 0; m_run = 0; m_flag = 0; m_evt = 0;
            m_mode = 0; m_per_pre = 0; m_div_pre = 0; m_per_sh = 0; m_div_sh = 0;
            m_psc = 0; m_cnt = 0;
        end else begin
            bit t, w, e, clr;
            int eff;
            t   = m_tick();
            eff = m_buf ? m_per_sh : m_per_pre;
            w   = t && m_cnt >= eff;
            e   = w && !m_dis;
            clr = wr_en && wr_addr == 2'd3 && wr_data[0];
            if (m_run && m_mode == 0 && !m_dir) m_psc = t ? 0 : m_psc + 1;
            if (t) m_cnt = w ? 0 : m_cnt + 1;
            if (e) begin m_per_sh = m_per_pre; m_div_sh = m_div_pre; end
            if (e) m_flag = 1; else if (clr) m_flag = 0;
            m_evt = e;
            m_run = m_en;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_en = wr_data[0]; m_buf = wr_data[1]; m_dis = wr_data[2];
                        m_mode = int'(wr_data[4:3]); m_dir = wr_data[5];
                    end
                    2'd1: m_per_pre = int'(wr_data);
                    2'd2: m_div_pre = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R5 count",  int'(count), m_cnt);
            chk("R5 evt",    int'(ovf_evt), int'(m_evt));
            chk("R6 flag",   int'(ovf_flag), int'(m_flag));
            chk("R3 run",    int'(run), int'(m_run));
            chk("R7 period", int'(period_active), m_per_sh);
            chk("R9 divide", int'(divide_active), m_div_sh);
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cw(bit en, bit bf, bit dis, int mode, bit dir);
        return {10'd0, dir, 2'(mode), dis, bf, en};
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(TCK * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog act=timeout exp=finished");
        summary();
        $finish;
    end

    initial begin
        int held, gap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        phase = "R1";
        chk("R1 count", int'(count), 0);
        chk("R1 flag", int'(ovf_flag), 0);
        chk("R1 period", int'(period_active), 0);
        chk("R1 divide", int'(divide_active), 0);
        chk("R1 run", int'(run), 0);
        cmp_on = 1;

        // R2/R3: unbuffered period 3, divide 0, enable
        phase = "R2";
        wr(2'd1, 16'd3);
        wr(2'd0, cw(1, 0, 0, 0, 0));
        phase = "R3";
        chk("R3 run one clock late", int'(run), 0);
        @(negedge clk);
        chk("R3 run high", int'(run), 1);
        chk("R3 no step yet", int'(count), 0);
        @(negedge clk);
        chk("R3 first step", int'(count), 1);
        repeat (20) @(negedge clk);

        // R7 buffered period
        phase = "R7";
        wr(2'd0, cw(1, 1, 0, 0, 0));
        held = int'(period_active);
        wr(2'd1, 16'd7);
        if (!ovf_evt) chk("R7 shadow held after write", int'(period_active), held);
        repeat (40) @(negedge clk);
        chk("R7 shadow loaded", int'(period_active), 7);

        // R9 divide shadow, R4 prescaler ratio
        phase = "R9";
        while (m_evt_next()) @(negedge clk);
        held = int'(divide_active);
        wr(2'd2, 16'd3);
        chk("R9 divide held after write", int'(divide_active), held);
        repeat (60) @(negedge clk);
        chk("R9 divide loaded", int'(divide_active), 3);
        phase = "R4";
        held = int'(count);
        while (int'(count) == held) @(negedge clk);
        held = int'(count); gap = 0;
        while (int'(count) == held && gap < 50) begin @(negedge clk); gap++; end
        chk("R4 clocks per step", gap, 4);

        // R8 unbuffered immediate shorter period
        phase = "R8";
        wr(2'd0, cw(1, 0, 0, 0, 0));
        gap = 0;
        while (int'(count) != 5 && gap < 200) begin @(negedge clk); gap++; end
        wr(2'd1, 16'd2);
        held = int'(count); gap = 0;
        while (int'(count) == held && gap < 50) begin @(negedge clk); gap++; end
        chk("R8 wrap after shorter period", int'(count), 0);
        repeat (30) @(negedge clk);

        // R6 clear and overflow on the same edge
        phase = "R6";
        gap = 0;
        while (!m_evt_next() && gap < 200) begin @(negedge clk); gap++; end
        wr(2'd3, 16'd1);
        chk("R6 set wins over clear", int'(ovf_flag), 1);
        while (m_evt_next()) @(negedge clk);
        wr(2'd3, 16'd1);
        chk("R6 clear on quiet edge", int'(ovf_flag), 0);
        repeat (20) @(negedge clk);
        chk("R6 flag sticky", int'(ovf_flag), 1);

        // R10 event disable
        phase = "R10";
        wr(2'd0, cw(1, 1, 1, 0, 0));
        wr(2'd3, 16'd1);
        held = int'(period_active);
        wr(2'd1, 16'd9);
        wr(2'd2, 16'd1);
        repeat (80) @(negedge clk);
        chk("R10 period frozen", int'(period_active), held);
        chk("R10 divide frozen", int'(divide_active), 3);
        chk("R10 flag not set", int'(ovf_flag), 0);

        // R11 disable freezes
        phase = "R11";
        wr(2'd0, cw(0, 1, 0, 0, 0));
        @(negedge clk);
        held = int'(count);
        repeat (10) @(negedge clk);
        chk("R11 count frozen", int'(count), held);

        // R12 non-up modes
        phase = "R12";
        wr(2'd0, cw(1, 1, 0, 1, 0));
        repeat (2) @(negedge clk);
        held = int'(count);
        repeat (12) @(negedge clk);
        chk("R12 mode 01 holds", int'(count), held);
        wr(2'd0, cw(1, 1, 0, 0, 1));
        repeat (2) @(negedge clk);
        held = int'(count);
        repeat (12) @(negedge clk);
        chk("R12 direction 1 holds", int'(count), held);
        wr(2'd0, cw(1, 1, 0, 0, 0));
        repeat (30) @(negedge clk);

        summary();
        $finish;
    end

endmodule